// File: doc/BRIEF.md
# Cascadable FIFO with Rewind

This block is a first-in first-out word buffer, nine bits wide by default, driven by active-low write and read strobes that are sampled on every rising clock edge. It reports empty, full and half-full status. In standalone operation a retransmit strobe rewinds the read side to the first location so that stored data can be sent again. Storage, pointers, flags, token handling and the read output enable are all modelled as synchronous logic in one clock domain; the output bus is driven to zero whenever its enable is low.

Several copies can be chained into a deeper buffer. With the chain-mode input high, a device only accepts writes while it holds a write token and only presents data while it holds a read token. The half-full pin then carries a one-cycle token pulse, emitted after the device writes or reads its last location, and the token input accepts pulses from the previous device in the ring. The first-load input picks the device that owns both tokens after reset.

The chain pulses arriving at a device alternate: the first grants the write token, the next the read token, and so on. Wiring each device's pulse output to the next device's token input forms the ring.

Top module: `fifo_cas`

## Requirements
- R1: Words leave the buffer in the order they were accepted; while the read strobe is low and a read is performed, `dout` shows the oldest stored word in that same cycle, and the read takes effect at the next rising edge.
- R2: A write is accepted at a rising edge when `wr_n` is low, the device may write (always in standalone mode, token held in chain mode) and the buffer is not full; a read likewise needs `rd_n` low, read permission and a non-empty buffer.
- R3: `full` is 1 exactly when DEPTH words are stored; a write attempted while full is dropped and `empty` and `full` are never both 1.
- R4: `empty` is 1 after reset and whenever no word is stored; a read attempted while empty does not advance the read side.
- R5: `dout_oe` is 1 only while `rd_n` is low and the device may read; whenever `dout_oe` is 0, `dout` is all zeros.
- R6: In standalone mode (`chain_mode` = 0) `hf_xo` is 1 exactly when at least DEPTH/2+1 words are stored.
- R7: In standalone mode, `rt_n` low at an edge moves the read side to location 0, sets the stored count to the write position (number of words written since reset, modulo DEPTH), and ignores any write or read in that cycle.
- R8: In chain mode (`chain_mode` = 1) `rt_n` has no effect.
- R9: In chain mode, after reset a device with `first_load` = 1 holds both tokens and one with `first_load` = 0 holds neither; without the write token writes are ignored, and without the read token `dout_oe` stays 0.
- R10: In chain mode, a write to the last location (DEPTH-1) releases the write token and raises `hf_xo` for exactly one cycle, starting at that same edge.
- R11: In chain mode, a read of the last location releases the read token and raises `hf_xo` for one cycle the same way; the receiving device takes a token at the edge after the pulse is seen, so one cycle passes with no owner.
- R12: In chain mode, token pulses seen on `xi` alternate in meaning, starting after reset with a write-token grant followed by a read-token grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Retransmit strobe, active low, standalone only |
| din | input | WIDTH | Write data |
| chain_mode | input | 1 | 0 standalone, 1 depth chain |
| first_load | input | 1 | Device owns both tokens after reset (chain mode) |
| xi | input | 1 | Token pulse from previous device |
| dout | output | WIDTH | Read data, zero when not enabled |
| dout_oe | output | 1 | Read data valid on bus |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| hf_xo | output | 1 | Half full (standalone) or token pulse out (chain) |

## Verification
The bench fills a small buffer to every occupancy and drives a long mixed stream of reads, writes and rewinds against an arithmetic model, so an off-by-one half-full threshold, a write that slips in while full, or a read pointer that moves while empty shows up as a wrong flag or a word out of order. Rewind is exercised with writes requested in the same cycle and after the write position has wrapped; a design that let the write through or restored the count from the read side would report the wrong occupancy. A two-device ring checks that writes stop at the token boundary, that each pulse lasts one cycle, that the second device treats its first pulse as a write grant and its second as a read grant, and that a chain-mode rewind leaves the data stream intact; a design that swapped grant order would lose the second half of the stream.

// File: rtl/fifo_cas_pkg.sv
package fifo_cas_pkg;

    typedef enum logic {
        MODE_SOLO  = 1'b0,
        MODE_CHAIN = 1'b1
    } chain_mode_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic rewind;
    } fifo_req_t;

    function automatic int half_level(input int depth);
        return depth / 2 + 1;
    endfunction

endpackage

// File: rtl/fifo_cas_store.sv
module fifo_cas_store #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_cas_ptrs.sv
module fifo_cas_ptrs
    import fifo_cas_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_req_t     req,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] level,
    output logic          wr_do,
    output logic          rd_do,
    output logic          wr_last,
    output logic          rd_last,
    output logic          is_empty,
    output logic          is_full
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign is_empty = (level == '0);
    assign is_full  = (level == CW'(DEPTH));

    // A rewind cycle swallows both strobes.
    assign wr_do   = req.wr && !is_full  && !req.rewind;
    assign rd_do   = req.rd && !is_empty && !req.rewind;
    assign wr_last = wr_do && (wptr == LAST);
    assign rd_last = rd_do && (rptr == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else if (req.rewind) begin
            rptr  <= '0;
            level <= {1'b0, wptr};
        end else begin
            if (wr_do) wptr <= wptr + 1'b1;
            if (rd_do) rptr <= rptr + 1'b1;
            level <= level + CW'(wr_do) - CW'(rd_do);
        end
    end

endmodule

// File: rtl/fifo_cas_token.sv
module fifo_cas_token
    import fifo_cas_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  chain_mode_e mode,
    input  logic        first_load,
    input  logic        xi,
    input  logic        wr_last,
    input  logic        rd_last,
    output logic        wr_tok,
    output logic        rd_tok,
    output logic        xo_pulse
);

    logic own_w;
    logic own_r;
    logic expect_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_w    <= first_load;
            own_r    <= first_load;
            expect_w <= 1'b1;
            xo_pulse <= 1'b0;
        end else begin
            xo_pulse <= (mode == MODE_CHAIN) && (wr_last || rd_last);
            if (wr_last) own_w <= 1'b0;
            if (rd_last) own_r <= 1'b0;
            // Incoming pulses alternate: write grant, then read grant.
            if ((mode == MODE_CHAIN) && xi) begin
                if (expect_w) own_w <= 1'b1;
                else          own_r <= 1'b1;
                expect_w <= !expect_w;
            end
        end
    end

    assign wr_tok = (mode == MODE_SOLO) || own_w;
    assign rd_tok = (mode == MODE_SOLO) || own_r;

endmodule

// File: rtl/fifo_cas.sv
module fifo_cas
    import fifo_cas_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int HALF = half_level(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rt_n,
    input  logic [WIDTH-1:0] din,
    input  logic             chain_mode,
    input  logic             first_load,
    input  logic             xi,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty,
    output logic             full,
    output logic             hf_xo
);

    chain_mode_e      mode_e;
    fifo_req_t        req;
    logic             wr_tok;
    logic             rd_tok;
    logic             xo_pulse;
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    level;
    logic             wr_do;
    logic             rd_do;
    logic             wr_last;
    logic             rd_last;
    logic [WIDTH-1:0] rdata;

    assign mode_e     = chain_mode_e'(chain_mode);
    assign req.wr     = !wr_n && wr_tok;
    assign req.rd     = !rd_n && rd_tok;
    assign req.rewind = !rt_n && (mode_e == MODE_SOLO);

    fifo_cas_token u_tok (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .first_load (first_load),
        .xi         (xi),
        .wr_last    (wr_last),
        .rd_last    (rd_last),
        .wr_tok     (wr_tok),
        .rd_tok     (rd_tok),
        .xo_pulse   (xo_pulse)
    );

    fifo_cas_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wptr     (wptr),
        .rptr     (rptr),
        .level    (level),
        .wr_do    (wr_do),
        .rd_do    (rd_do),
        .wr_last  (wr_last),
        .rd_last  (rd_last),
        .is_empty (empty),
        .is_full  (full)
    );

    fifo_cas_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .we    (wr_do),
        .waddr (wptr),
        .wdata (din),
        .raddr (rptr),
        .rdata (rdata)
    );

    assign dout_oe = !rd_n && rd_tok;
    assign dout    = dout_oe ? rdata : '0;
    assign hf_xo   = (mode_e == MODE_CHAIN) ? xo_pulse : (level >= CW'(HALF));

endmodule

// File: rtl/fifo_cas_chk.sv
module fifo_cas_chk #(
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             chain_mode,
    input logic             wr_n,
    input logic             rd_n,
    input logic             rt_n,
    input logic [WIDTH-1:0] dout,
    input logic             dout_oe,
    input logic             empty,
    input logic             full,
    input logic             hf_xo,
    input logic             rd_tok
);

    p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (full && rd_n && (rt_n || chain_mode)) |=> full);

    p_flags_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    p_empty_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_n && (rt_n || chain_mode)) |=> empty);

    p_bus_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        rd_n |-> (!dout_oe && (dout == '0)));

    p_rewind_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (chain_mode && !rt_n && wr_n && rd_n) |=> ($stable(empty) && $stable(full)));

    p_token_bus_r9: assert property (@(posedge clk) disable iff (rst)
        (chain_mode && !rd_tok) |-> !dout_oe);

    p_xo_single_r10: assert property (@(posedge clk) disable iff (rst)
        (chain_mode && hf_xo) ##1 chain_mode |-> !hf_xo);

endmodule

bind fifo_cas fifo_cas_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chain_mode (chain_mode),
    .wr_n       (wr_n),
    .rd_n       (rd_n),
    .rt_n       (rt_n),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .empty      (empty),
    .full       (full),
    .hf_xo      (hf_xo),
    .rd_tok     (rd_tok)
);

// File: tb/fifo_cas_bench.sv
module fifo_cas_bench;

    localparam int D = 8;
    localparam int W = 9;
    localparam int HF = D / 2 + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1, mode = 1'b0;
    logic [W-1:0] din = '0;

    logic [W-1:0] a_dout, b_dout;
    logic a_oe, a_empty, a_full, a_xo;
    logic b_oe, b_empty, b_full, b_xo;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fifo_cas #(.DEPTH(D), .WIDTH(W)) u_fifo_cas (
        .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
        .chain_mode(mode), .first_load(1'b1), .xi(b_xo),
        .dout(a_dout), .dout_oe(a_oe), .empty(a_empty), .full(a_full), .hf_xo(a_xo)
    );

    fifo_cas #(.DEPTH(D), .WIDTH(W)) u_fifo_cas_peer (
        .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .din(din),
        .chain_mode(mode), .first_load(1'b0), .xi(a_xo),
        .dout(b_dout), .dout_oe(b_oe), .empty(b_empty), .full(b_full), .hf_xo(b_xo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of a standalone buffer.
    logic [W-1:0] mdl [D];
    int mw, mr, mc;

    task automatic do_reset(input logic m);
        @(negedge clk);
        mode = m; rst = 1'b1; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mw = 0; mr = 0; mc = 0;
    endtask

    task automatic step(input bit w, input bit r, input bit t, input logic [W-1:0] d);
        bit dw, dr;
        @(negedge clk);
        wr_n = !w; rd_n = !r; rt_n = !t; din = d;
        #1;
        chk(a_oe == r, "R5 enable follows read strobe", a_oe, r);
        if (!r) chk(a_dout == '0, "R5 idle bus zero", a_dout, 0);
        if (r && !t && mc > 0) chk(a_dout == mdl[mr], "R1 order", a_dout, mdl[mr]);
        if (t) begin
            mr = 0; mc = mw;
        end else begin
            dw = w && (mc < D);
            dr = r && (mc > 0);
            if (dw) begin mdl[mw] = d; mw = (mw + 1) % D; end
            if (dr) mr = (mr + 1) % D;
            mc = mc + int'(dw) - int'(dr);
        end
        @(posedge clk); #1;
        chk(a_empty == (mc == 0), "R4 empty flag", a_empty, mc == 0);
        chk(a_full == (mc == D), "R3 full flag", a_full, mc == D);
        chk(a_xo == (mc >= HF), "R6 half full", a_xo, mc >= HF);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    endtask

    initial begin
        logic [15:0] lf;
        logic [W-1:0] bus;

        // Reset state
        do_reset(1'b0);
        #1;
        chk(a_empty, "R4 empty after reset", a_empty, 1);
        chk(!a_full && !a_xo, "R3 R6 flags low after reset", {a_full, a_xo}, 0);
        chk(!a_oe && a_dout == '0, "R5 bus idle after reset", a_dout, 0);

        // Every occupancy: fill to n, push one more, drain, read on empty.
        for (int n = 0; n <= D; n++) begin
            do_reset(1'b0);
            for (int i = 0; i < n; i++) step(1, 0, 0, W'(9'h100 + n * 16 + i));
            step(1, 0, 0, 9'h0aa);                    // R3 dropped when full
            for (int i = 0; i < D + 1; i++) step(0, 1, 0, '0);
            step(0, 1, 0, '0);                        // R4 read on empty
            step(1, 0, 0, 9'h1c3);
            step(0, 1, 0, '0);                        // R2 fresh word appears
            idle();
        end

        // Simultaneous read/write and mixed traffic, with rewinds.
        do_reset(1'b0);
        lf = 16'hace1;
        for (int k = 0; k < 600; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (k < 300) step(lf[0] | lf[1], lf[2] & lf[3], lf[7:4] == 4'h0, W'(lf[12:4]));
            else         step(lf[0] & lf[1], lf[2] | lf[3], lf[7:4] == 4'h0, W'(lf[12:4]));
        end
        idle();

        // R7: rewind restores the count from the write side, drops a write.
        do_reset(1'b0);
        for (int i = 0; i < 5; i++) step(1, 0, 0, W'(9'h150 + i));
        for (int i = 0; i < 3; i++) step(0, 1, 0, '0);
        step(1, 0, 1, 9'h0ff);
        chk(a_xo == 1'b1, "R7 count restored to five", a_xo, 1);
        for (int i = 0; i < 5; i++) step(0, 1, 0, '0);
        chk(a_empty, "R7 no extra word after rewind", a_empty, 1);
        idle();

        // Two-device chain.
        do_reset(1'b1);
        for (int i = 0; i < 2 * D + 1; i++) begin
            @(negedge clk);
            wr_n = 1'b0; din = W'(9'h100 | i);
            @(posedge clk); #1;
            if (i == 0) chk(b_empty, "R9 peer without token ignores write", b_empty, 1);
            if (i == D - 1) begin
                chk(a_xo, "R10 write handoff pulse", a_xo, 1);
                chk(a_full, "R3 first device full", a_full, 1);
                @(negedge clk); wr_n = 1'b1;     // token in flight
                @(posedge clk); #1;
                chk(!a_xo, "R10 pulse lasts one cycle", a_xo, 0);
            end
            if (i == 2 * D - 1) chk(b_full && b_xo, "R12 first pulse grants write", {b_full, b_xo}, 3);
        end
        idle();
        @(posedge clk); #1;
        chk(a_full && b_full, "R3 extra chain write dropped", {a_full, b_full}, 3);

        for (int i = 0; i < 2 * D; i++) begin
            if (i == 4) begin
                @(negedge clk); rd_n = 1'b1; rt_n = 1'b0;
                @(posedge clk); #1;
                chk(!a_empty && !a_full, "R8 rewind ignored in chain", {a_empty, a_full}, 0);
                rt_n = 1'b1;
            end
            if (i == D) begin
                @(negedge clk); rd_n = 1'b0; #1;
                chk(!a_oe && !b_oe, "R11 no owner during handoff", {a_oe, b_oe}, 0);
                @(posedge clk); #1;
            end
            @(negedge clk); rd_n = 1'b0; #1;
            bus = a_oe ? a_dout : b_dout;
            chk((a_oe ^ b_oe) == 1'b1, "R9 single bus owner", {a_oe, b_oe}, i < D ? 2 : 1);
            chk(bus == W'(9'h100 | i), "R1 chain order", bus, 9'h100 | i);
            if (i >= D) chk(b_oe, "R12 second pulse grants read", b_oe, 1);
            @(posedge clk); #1;
            if (i == D - 1) chk(a_xo && a_empty, "R11 read handoff pulse", {a_xo, a_empty}, 3);
        end
        idle();
        @(posedge clk); #1;
        chk(a_empty && b_empty, "R4 chain drained", {a_empty, b_empty}, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule